// File: doc/BRIEF.md
# StreamID Pattern-Match Event Filter

This block decides, for each of a set of performance counters, whether an incoming event tagged with a StreamID should be counted. Each counter has its own match value and a mode bit. In exact mode, the whole StreamID must equal the match value. In span mode, the match value carries its own wildcard width: its lowest zero bit, together with all the ones below it, marks the low bits to ignore. The bits above that zero must still agree with the StreamID. For example, a 32-bit match value of 0x42 in span mode accepts StreamIDs 0x42 and 0x43 and nothing else.

Software programs one counter at a time through a write port. That port carries a counter select, a match value, a mode bit and a filter-enable bit. When filter-enable is low on a write, the counter is loaded with the pass-everything setting (span mode with an all-ones value), whatever the other write fields hold. The same setting is loaded at reset.

Each event is a one-cycle strobe with a StreamID. The block returns one registered count-enable bit per counter, one cycle after the strobe. Counter storage, event-type selection and bus decoding sit outside this block.

Top module: `sidf_filter`

## Requirements
- R1: After reset every counter holds the pass-all setting (span mode, all-ones match), and every count-enable bit is 0.
- R2: In exact mode (mode bit 0), count-enable bit k is 1 in the cycle after a valid event if and only if the event StreamID equals counter k's match value in every bit.
- R3: In span mode (mode bit 1), let Y-1 be the position of the lowest zero bit in the match value. The StreamID bits 0 to Y-1 do not affect the result. Span mode therefore always ignores at least bit 0.
- R4: In span mode, every StreamID bit from position Y upward must equal the match bit in the same position, or the count-enable bit stays 0.
- R5: A span-mode match value whose bit 0 is zero and whose bit 1 is one (for example 0x42) accepts exactly two StreamIDs: the value itself and the value plus one.
- R6: A span-mode match value of all ones accepts every StreamID.
- R7: A write with filter-enable low loads the selected counter with the pass-all setting, whatever the match and mode fields hold.
- R8: A count-enable bit is 1 only in the cycle right after a cycle with the event strobe high. With no strobe, every count-enable bit is 0 whatever the StreamID.
- R9: A write changes only the counter it selects. An event in the same cycle as a write is judged against the settings held before that write.
- R10: A write whose select is not below the number of counters changes no counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for one counter's filter settings |
| cfg_sel | input | SEL_W | Counter index for the write |
| cfg_filt_en | input | 1 | 1 loads the given value and mode; 0 loads the pass-all setting |
| cfg_match | input | SID_W | Match value to load |
| cfg_span | input | 1 | Mode to load: 0 exact, 1 span |
| evt_valid | input | 1 | Event strobe |
| evt_sid | input | SID_W | StreamID of the event |
| cnt_en | output | NUM_CTR | Registered count-enable, one bit per counter |

## Verification
On every cycle, the assertions check the following:
- an absent strobe yields no count-enable;
- exact-mode hits and misses follow equality with the stored value;
- an all-ones span value always passes;
- a mismatch in the top StreamID bit blocks a span-mode hit whenever that bit is not a wildcard;
- writes leave the other counters' settings untouched.

Only the bench's scenarios can show the following:
- the exact wildcard width for every possible match value, using a full sweep of a 6-bit configuration;
- the two-value window of the 0x42-style pattern;
- the old-settings rule for an event that coincides with a write;
- the effect of out-of-range selects and filter-disable writes.

// File: rtl/sidf_pkg.sv
package sidf_pkg;

    typedef enum logic {
        MODE_EXACT = 1'b0,
        MODE_SPAN  = 1'b1
    } sidf_mode_e;

endpackage

// File: rtl/sidf_span_mask.sv
// Trailing-ones scan: a bit is a wildcard when every bit below it in the
// match value is one. This covers the lowest zero bit and all ones below it.
module sidf_span_mask #(
    parameter int SID_W = 32
) (
    input  logic [SID_W-1:0] match_i,
    output logic [SID_W-1:0] wild_o
);

    always_comb begin : p_scan
        logic run;
        run = 1'b1;
        for (int i = 0; i < SID_W; i++) begin
            wild_o[i] = run;
            run       = run & match_i[i];
        end
    end

endmodule

// File: rtl/sidf_match.sv
module sidf_match
    import sidf_pkg::*;
#(
    parameter int SID_W = 32
) (
    input  logic [SID_W-1:0] match_i,
    input  sidf_mode_e       mode_i,
    input  logic [SID_W-1:0] sid_i,
    output logic             hit_o
);

    logic [SID_W-1:0] wild;
    logic [SID_W-1:0] care;

    sidf_span_mask #(.SID_W(SID_W)) u_mask (
        .match_i (match_i),
        .wild_o  (wild)
    );

    always_comb begin
        care  = (mode_i == MODE_SPAN) ? ~wild : {SID_W{1'b1}};
        hit_o = (((match_i ^ sid_i) & care) == '0);
    end

endmodule

// File: rtl/sidf_filter.sv
module sidf_filter
    import sidf_pkg::*;
#(
    parameter int SID_W   = 32,
    parameter int NUM_CTR = 4,
    localparam int SEL_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic               cfg_filt_en,
    input  logic [SID_W-1:0]   cfg_match,
    input  logic               cfg_span,
    input  logic               evt_valid,
    input  logic [SID_W-1:0]   evt_sid,
    output logic [NUM_CTR-1:0] cnt_en
);

    typedef struct packed {
        logic [SID_W-1:0] match;
        sidf_mode_e       mode;
    } ctr_cfg_t;

    typedef struct packed {
        ctr_cfg_t [NUM_CTR-1:0] cfg;
        logic [NUM_CTR-1:0]     en;
    } state_t;

    localparam ctr_cfg_t CFG_PASS_ALL = '{match: {SID_W{1'b1}}, mode: MODE_SPAN};

    state_t             st_d, st_q;
    logic [NUM_CTR-1:0] hit;

    // Flattened views for the bound checker
    logic [NUM_CTR-1:0][SID_W-1:0] match_view;
    logic [NUM_CTR-1:0]            span_view;

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
        sidf_match #(.SID_W(SID_W)) u_match (
            .match_i (st_q.cfg[k].match),
            .mode_i  (st_q.cfg[k].mode),
            .sid_i   (evt_sid),
            .hit_o   (hit[k])
        );
        assign match_view[k] = st_q.cfg[k].match;
        assign span_view[k]  = (st_q.cfg[k].mode == MODE_SPAN);
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NUM_CTR; k++) begin
            if (cfg_we && (cfg_sel == SEL_W'(k))) begin
                if (cfg_filt_en) begin
                    st_d.cfg[k].match = cfg_match;
                    st_d.cfg[k].mode  = sidf_mode_e'(cfg_span);
                end else begin
                    st_d.cfg[k] = CFG_PASS_ALL;
                end
            end
        end
        st_d.en = evt_valid ? hit : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_CTR; k++) begin
                st_q.cfg[k] <= CFG_PASS_ALL;
            end
            st_q.en <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_en = st_q.en;

endmodule

// File: rtl/sidf_filter_chk.sv
module sidf_filter_chk #(
    parameter int SID_W   = 32,
    parameter int NUM_CTR = 4,
    parameter int SEL_W   = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cfg_we,
    input logic [SEL_W-1:0]              cfg_sel,
    input logic                          evt_valid,
    input logic [SID_W-1:0]              evt_sid,
    input logic [NUM_CTR-1:0]            cnt_en,
    input logic [NUM_CTR-1:0][SID_W-1:0] match_view,
    input logic [NUM_CTR-1:0]            span_view
);

    a_r8_no_strobe_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |=> (cnt_en == '0));

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_k
        a_r2_exact_hit: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_valid && !span_view[k] && (evt_sid == match_view[k])) |=> cnt_en[k]);

        a_r2_exact_miss: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_valid && !span_view[k] && (evt_sid != match_view[k])) |=> !cnt_en[k]);

        a_r6_all_ones_pass: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_valid && span_view[k] && (match_view[k] == {SID_W{1'b1}})) |=> cnt_en[k]);

        a_r4_top_bit_compared: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_valid && span_view[k] && (~match_view[k][SID_W-2:0] != '0)
             && (evt_sid[SID_W-1] != match_view[k][SID_W-1])) |=> !cnt_en[k]);

        a_r9_other_ctr_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && (cfg_sel != SEL_W'(k))) |=>
            ($stable(match_view[k]) && $stable(span_view[k])));
    end

endmodule

bind sidf_filter sidf_filter_chk #(
    .SID_W   (SID_W),
    .NUM_CTR (NUM_CTR),
    .SEL_W   (SEL_W)
) u_sidf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .evt_valid  (evt_valid),
    .evt_sid    (evt_sid),
    .cnt_en     (cnt_en),
    .match_view (match_view),
    .span_view  (span_view)
);

// File: tb/sidf_filter_bench.sv
`timescale 1ns/1ps
module sidf_filter_bench;

    localparam int W  = 6;
    localparam int N  = 3;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [SW-1:0] cfg_sel = '0;
    logic          cfg_filt_en = 1'b0;
    logic [W-1:0]  cfg_match = '0;
    logic          cfg_span = 1'b0;
    logic          evt_valid = 1'b0;
    logic [W-1:0]  evt_sid = '0;
    logic [N-1:0]  cnt_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sidf_filter #(.SID_W(W), .NUM_CTR(N)) u_sidf_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_filt_en (cfg_filt_en),
        .cfg_match   (cfg_match),
        .cfg_span    (cfg_span),
        .evt_valid   (evt_valid),
        .evt_sid     (evt_sid),
        .cnt_en      (cnt_en)
    );

    // Reference: span wildcard bits = m ^ (m + 1), which wraps to all ones for m = all ones
    function automatic bit model(logic [W-1:0] m, bit span, logic [W-1:0] sid);
        logic [W-1:0] wild;
        if (!span) return (m == sid);
        wild = m ^ (m + W'(1));
        return (((m ^ sid) & ~wild) == '0);
    endfunction

    task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr(logic [SW-1:0] sel, bit fe, logic [W-1:0] m, bit s);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_filt_en = fe; cfg_match = m; cfg_span = s;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive one event, return count-enable one cycle later
    task automatic ev(bit v, logic [W-1:0] sid, output logic [N-1:0] res);
        @(negedge clk);
        evt_valid = v; evt_sid = sid;
        @(negedge clk);
        res = cnt_en;
        evt_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [N-1:0] r;
        int hits;
        repeat (3) @(negedge clk);
        chk("R1 reset cnt_en", cnt_en, '0);
        rst_n = 1'b1;

        // R1 R6: reset setting passes every StreamID on all counters
        for (int sid = 0; sid < (1 << W); sid++) begin
            ev(1'b1, W'(sid), r);
            chk("R1 R6 default pass-all", r, '1);
        end

        // R8: no strobe, no count
        for (int sid = 0; sid < 8; sid++) begin
            ev(1'b0, W'(sid), r);
            chk("R8 no strobe", r, '0);
        end

        // R2 R3 R4: full sweep of match value and mode; counter 2 stays default
        for (int m = 0; m < (1 << W); m++) begin
            for (int s = 0; s < 2; s++) begin
                wr(2'd0, 1'b1, W'(m), s[0]);
                wr(2'd1, 1'b1, W'(m) ^ W'(21), ~s[0]);
                for (int sid = 0; sid < (1 << W); sid++) begin
                    logic [N-1:0] e;
                    e[0] = model(W'(m), s[0], W'(sid));
                    e[1] = model(W'(m) ^ W'(21), ~s[0], W'(sid));
                    e[2] = 1'b1;
                    ev(1'b1, W'(sid), r);
                    chk("R2 R3 R4 sweep", r, e);
                end
            end
        end

        // R5: 0b100010 in span mode accepts only itself and itself plus one
        wr(2'd0, 1'b1, W'(6'h22), 1'b1);
        hits = 0;
        for (int sid = 0; sid < (1 << W); sid++) begin
            ev(1'b1, W'(sid), r);
            if (r[0]) hits++;
            if (sid == 6'h22 || sid == 6'h23) chk("R5 window hit", {2'b00, r[0]}, 3'b001);
        end
        chk("R5 window size", N'(hits), N'(2));

        // R7: filter-enable low loads pass-all regardless of fields
        wr(2'd0, 1'b0, W'(0), 1'b0);
        wr(2'd1, 1'b0, W'(6'h15), 1'b0);
        wr(2'd2, 1'b0, W'(0), 1'b0);
        for (int sid = 0; sid < (1 << W); sid++) begin
            ev(1'b1, W'(sid), r);
            chk("R7 disable write pass-all", r, '1);
        end

        // R10: out-of-range select changes nothing
        wr(2'd3, 1'b1, W'(0), 1'b0);
        for (int sid = 1; sid < (1 << W); sid++) begin
            ev(1'b1, W'(sid), r);
            chk("R10 out-of-range write", r, '1);
        end

        // R9: write and event in the same cycle use the old settings
        wr(2'd0, 1'b1, W'(5), 1'b0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_filt_en = 1'b1; cfg_match = W'(7); cfg_span = 1'b0;
        evt_valid = 1'b1; evt_sid = W'(5);
        @(negedge clk);
        cfg_we = 1'b0; evt_valid = 1'b0;
        chk("R9 same-cycle old settings", cnt_en, 3'b111);
        ev(1'b1, W'(7), r);
        chk("R9 new value hit", r, 3'b111);
        ev(1'b1, W'(5), r);
        chk("R9 old value now misses", r, 3'b110);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule